// File: doc/BRIEF.md
# Four-Channel PWM Generator with Staged Settings

The block drives a bank of independent pulse-width outputs from one shared reference tick. Each channel has a count limit (its period), a compare value (its duty) and a small control word. The control word picks a power-of-two prescaler applied to the reference tick and can invert the output. The reference tick is a one-cycle enable strobe at a fixed rate (nominally 1 MHz) that arrives in the fast system clock domain.

Software writes go into staged copies, and nothing on an output changes when they land. A write to a channel's period register marks that channel as pending. When the running period reaches its last count, the staged period, duty, prescaler and polarity all move into the live set in one clock. An idle channel has nothing to finish, so it picks up the staged set at once. A staged period of zero stops the channel at the end of the running period, and its output then stays low. Reads return the staged values.

Top module: `pwm_shadow_bank`

## Requirements
- R1: After reset every register reads 0 and every output is low.
- R2: Channel c has its period at byte address 0x400+4c, its duty at 0x420+4c and its control word at 0x440+4c. Period and duty keep the low 16 bits of the written word. The control word keeps bits [1:0] (prescaler) and bit 5 (invert); all its other bits read 0. Any other address reads 0. A read returns the latest written value.
- R3: Duty and control writes alone never change any output.
- R4: A period write arms the channel. The staged period, duty, prescaler and polarity become live together, one clock after the reference tick that ends the running period.
- R5: When a nonzero period is written to an idle channel, the output takes its new value on the second rising clock edge after the write cycle, without waiting for a tick.
- R6: With polarity normal, the output is high while the period position (in prescaled ticks, counting from 0) is below the duty, and low for the rest of the period.
- R7: A duty of 0 keeps a running output low all the time. A duty at or above the period keeps it high all the time.
- R8: With control bit 5 set, a running channel's output is the complement of the R6 waveform.
- R9: Prescaler code N in bits [1:0] makes each period step last 2^N reference ticks.
- R10: A period write of 0 stops the channel once its running period ends. From then on the output stays low, whatever the polarity.
- R11: Channels run independently, and writes to one channel do not disturb another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Reference tick strobe, one clock wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Write byte address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 12 | Read byte address |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| pwm_o | output | 4 | One PWM output per channel |

## Verification
If the live set or the pending flag goes wrong, an output edge moves. The output switches a full period early or late, or a stopped channel keeps toggling, and this shows at pwm_o within one period of the channel involved. A position counter that goes wrong bends the duty boundary within a single prescaled step. The output is therefore compared in every clock against a model that follows positions in reference ticks. Staged-value errors show on the very next read of the same address.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int CNT_W   = 16;
  localparam int DIV_W   = 2;
  localparam int PRE_W   = (1 << DIV_W) - 1;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int INV_BIT = 5;
  localparam int STRIDE  = 4;

  localparam logic [ADDR_W-1:0] PER_BASE  = 12'h400;
  localparam logic [ADDR_W-1:0] DUTY_BASE = 12'h420;
  localparam logic [ADDR_W-1:0] CTL_BASE  = 12'h440;

  typedef struct packed {
    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] duty;
    logic [DIV_W-1:0] div;
    logic             inv;
  } pwm_cfg_t;

  function automatic logic [ADDR_W-1:0] reg_addr(logic [ADDR_W-1:0] base, int ch);
    return base + ADDR_W'(STRIDE * ch);
  endfunction
endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_shadow_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [DATA_W-1:0]       rd_data_o,
  output pwm_cfg_t [NUM_CH-1:0]   cfg_o,
  output logic [NUM_CH-1:0]       arm_o
);
  pwm_cfg_t [NUM_CH-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_en_i) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_addr_i == reg_addr(PER_BASE, c))  cfg_q[c].per  <= wr_data_i[CNT_W-1:0];
        if (wr_addr_i == reg_addr(DUTY_BASE, c)) cfg_q[c].duty <= wr_data_i[CNT_W-1:0];
        if (wr_addr_i == reg_addr(CTL_BASE, c)) begin
          cfg_q[c].div <= wr_data_i[DIV_W-1:0];
          cfg_q[c].inv <= wr_data_i[INV_BIT];
        end
      end
    end
  end

  // period write is the commit trigger
  always_comb begin
    for (int c = 0; c < NUM_CH; c++)
      arm_o[c] = wr_en_i && (wr_addr_i == reg_addr(PER_BASE, c));
  end

  always_comb begin
    rd_data_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr_i == reg_addr(PER_BASE, c))  rd_data_o = DATA_W'(cfg_q[c].per);
      if (rd_addr_i == reg_addr(DUTY_BASE, c)) rd_data_o = DATA_W'(cfg_q[c].duty);
      if (rd_addr_i == reg_addr(CTL_BASE, c)) begin
        rd_data_o[DIV_W-1:0] = cfg_q[c].div;
        rd_data_o[INV_BIT]   = cfg_q[c].inv;
      end
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_shadow_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             arm_i,
  input  pwm_cfg_t         shadow_i,
  output logic             pwm_o,
  output logic [CNT_W-1:0] act_per_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pend_o
);
  pwm_cfg_t         act_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic             pend_q;

  logic             running;
  logic [PRE_W-1:0] pre_mask;
  logic             ptick;
  logic             last;
  logic             load;

  assign running  = act_q.per != '0;
  assign pre_mask = PRE_W'((32'd1 << act_q.div) - 32'd1);
  assign ptick    = running && tick_i && ((pre_q & pre_mask) == pre_mask);
  assign last     = ptick && (cnt_q == act_q.per - CNT_W'(1));
  // idle channel commits at once, running one waits for its last step
  assign load     = pend_q && (!running || last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      cnt_q  <= '0;
      pre_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= arm_i | (pend_q & ~load);
      if (load) begin
        act_q <= shadow_i;
        cnt_q <= '0;
        pre_q <= '0;
      end else if (running && tick_i) begin
        pre_q <= pre_q + PRE_W'(1);
        if (ptick) cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
      end
    end
  end

  assign pwm_o     = running && ((cnt_q < act_q.duty) ^ act_q.inv);
  assign act_per_o = act_q.per;
  assign cnt_o     = cnt_q;
  assign pend_o    = pend_q;
endmodule

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank
  import pwm_shadow_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NUM_CH-1:0] pwm_o
);
  pwm_cfg_t [NUM_CH-1:0]         shadow;
  logic [NUM_CH-1:0]             arm;
  logic [NUM_CH-1:0]             pend;
  logic [NUM_CH-1:0][CNT_W-1:0]  act_per;
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt;

  pwm_shadow_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .cfg_o     (shadow),
    .arm_o     (arm)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_chan u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .arm_i     (arm[g]),
      .shadow_i  (shadow[g]),
      .pwm_o     (pwm_o[g]),
      .act_per_o (act_per[g]),
      .cnt_o     (cnt[g]),
      .pend_o    (pend[g])
    );
  end
endmodule

// File: rtl/pwm_shadow_bank_chk.sv
module pwm_shadow_bank_chk
  import pwm_shadow_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         tick_i,
  input logic                         wr_en_i,
  input logic [ADDR_W-1:0]            wr_addr_i,
  input logic [DATA_W-1:0]            wr_data_i,
  input logic [ADDR_W-1:0]            rd_addr_i,
  input logic [DATA_W-1:0]            rd_data_i,
  input logic [NUM_CH-1:0]            pwm_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] act_per_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_i,
  input logic [NUM_CH-1:0]            pend_i
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R10
    idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_per_i[g] == '0) |-> !pwm_i[g]);
    // R4
    per_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(act_per_i[g]) |-> $past(pend_i[g]));
    // R6
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_per_i[g] != '0) |-> (cnt_i[g] < act_per_i[g]));
    // R3
    out_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(pwm_i[g]) |-> ($past(tick_i) || $past(pend_i[g])));
  end

  // R2
  per_rdbk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i && (wr_addr_i == PER_BASE)) && (rd_addr_i == PER_BASE))
    |-> (rd_data_i == DATA_W'($past(wr_data_i[CNT_W-1:0]))));
endmodule

bind pwm_shadow_bank pwm_shadow_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .rd_addr_i (rd_addr_i),
  .rd_data_i (rd_data_o),
  .pwm_i     (pwm_o),
  .act_per_i (act_per),
  .cnt_i     (cnt),
  .pend_i    (pend)
);

// File: tb/pwm_shadow_bank_tb_top.sv
module pwm_shadow_bank_tb_top;
  import pwm_shadow_pkg::*;
  localparam int NC = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic [NC-1:0]     pwm;

  always #5 clk = ~clk;

  pwm_shadow_bank #(.NUM_CH(NC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .pwm_o(pwm)
  );

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    chk_on = 0, tick_en = 0, done = 0;
  int    tick_gap = 2, tcnt = 0;

  // reference model: positions kept in raw reference ticks
  int sh_per[NC], sh_duty[NC], sh_ctl[NC];
  int a_per[NC], a_duty[NC], a_div[NC], a_inv[NC], pend[NC], pos[NC];

  function automatic void model_reset();
    for (int c = 0; c < NC; c++) begin
      sh_per[c] = 0; sh_duty[c] = 0; sh_ctl[c] = 0;
      a_per[c] = 0; a_duty[c] = 0; a_div[c] = 0; a_inv[c] = 0;
      pend[c] = 0; pos[c] = 0;
    end
  endfunction

  function automatic void model_step();
    for (int c = 0; c < NC; c++) begin
      int last_pos = (a_per[c] << a_div[c]) - 1;
      bit ld = pend[c] && (a_per[c] == 0 || (tick && pos[c] == last_pos));
      if (ld) begin
        a_per[c] = sh_per[c]; a_duty[c] = sh_duty[c];
        a_div[c] = sh_ctl[c] & 3; a_inv[c] = (sh_ctl[c] >> 5) & 1;
        pend[c] = 0; pos[c] = 0;
      end else if (a_per[c] != 0 && tick) begin
        pos[c] = (pos[c] == last_pos) ? 0 : pos[c] + 1;
      end
    end
    if (wr_en) begin
      for (int c = 0; c < NC; c++) begin
        if (int'(wr_addr) == 'h400 + 4*c) begin sh_per[c] = int'(wr_data) & 'hFFFF; pend[c] = 1; end
        if (int'(wr_addr) == 'h420 + 4*c) sh_duty[c] = int'(wr_data) & 'hFFFF;
        if (int'(wr_addr) == 'h440 + 4*c) sh_ctl[c] = int'(wr_data) & 'h23;
      end
    end
  endfunction

  function automatic logic [NC-1:0] exp_pwm();
    logic [NC-1:0] v;
    for (int c = 0; c < NC; c++)
      v[c] = (a_per[c] != 0) && (((pos[c] >> a_div[c]) < a_duty[c]) ^ (a_inv[c] != 0));
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && rst_n) chk(cur_req, "pwm_o", 32'(pwm), 32'(exp_pwm()));
  end

  always @(negedge clk) begin
    if (tick_en) begin
      tcnt++;
      tick <= (tcnt % tick_gap) == 0;
    end else begin
      tick <= 1'b0;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, int a, int exp);
    @(negedge clk);
    rd_addr = ADDR_W'(a);
    #1;
    chk(req, $sformatf("read %0h", a), rd_data, 32'(exp));
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic all_zero(string req);
    for (int c = 0; c < NC; c++) begin
      rd_chk(req, 'h400 + 4*c, 0);
      rd_chk(req, 'h420 + 4*c, 0);
      rd_chk(req, 'h440 + 4*c, 0);
    end
    chk(req, "pwm_o after reset", 32'(pwm), 0);
  endtask

  task automatic hold_chk(string req, int c, bit lvl, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, $sformatf("ch%0d held level", c), 32'(pwm[c]), 32'(lvl));
    end
  endtask

  initial begin
    void'($urandom(32'd20517));
    cycles(3);
    rst_n = 1'b1;
    // R1 reset state
    all_zero("R1");
    chk_on = 1;

    // R2 map, truncation and masking, ticks off so nothing runs
    cur_req = "R2";
    wr('h404, 'h12345);      rd_chk("R2", 'h404, 'h2345);
    wr('h428, 'hABCDE);      rd_chk("R2", 'h428, 'hBCDE);
    wr('h44C, 'hFFFFFFFF);   rd_chk("R2", 'h44C, 'h23);
    wr('h440, 'h1);          rd_chk("R2", 'h440, 'h1);
    rd_chk("R2", 'h460, 0);
    rd_chk("R2", 'h402, 0);
    rd_chk("R2", 'h000, 0);

    // mid-run reset returns to the R1 state
    @(negedge clk); rst_n = 1'b0;
    cycles(2);
    rst_n = 1'b1;
    all_zero("R1");

    // R5 idle start without any tick
    cur_req = "R5";
    wr('h440, 0); wr('h420, 3); wr('h400, 5);
    chk("R5", "ch0 before commit", 32'(pwm[0]), 0);
    @(negedge clk);
    chk("R5", "ch0 after commit", 32'(pwm[0]), 1);
    cycles(4);

    tick_en = 1;
    cur_req = "R6";
    wr('h428, 3); wr('h408, 7);
    cycles(120);
    cur_req = "R9";
    wr('h444, 2); wr('h424, 1); wr('h404, 3);
    cycles(150);
    cur_req = "R8";
    wr('h44C, 'h21); wr('h42C, 2); wr('h40C, 5);
    cycles(150);

    // R3 staged writes only
    cur_req = "R3";
    wr('h424, 2); wr('h444, 'h20); wr('h42C, 0);
    cycles(200);
    // R4 commit at period end
    cur_req = "R4";
    wr('h404, 4);
    cycles(200);

    // R7 duty extremes
    cur_req = "R7";
    wr('h428, 0); wr('h408, 7);
    cycles(60);
    hold_chk("R7", 2, 1'b0, 40);
    wr('h428, 9); wr('h408, 7);
    cycles(60);
    hold_chk("R7", 2, 1'b1, 40);

    // R10 stop an inverted channel
    cur_req = "R10";
    wr('h44C, 'h21); wr('h42C, 1); wr('h40C, 5);
    cycles(60);
    wr('h40C, 0);
    cycles(60);
    hold_chk("R10", 3, 1'b0, 60);
    rd_chk("R10", 'h40C, 0);

    // R11 random traffic across channels
    cur_req = "R11";
    for (int i = 0; i < 120; i++) begin
      int c = $urandom % NC;
      int k = $urandom % 3;
      cycles($urandom % 60);
      if (k == 0) wr('h400 + 4*c, ($urandom % 8 == 0) ? 0 : 1 + $urandom % 12);
      else if (k == 1) wr('h420 + 4*c, $urandom % 15);
      else wr('h440 + 4*c, int'($urandom & 32'hFFFF_FFE3));
    end
    cycles(300);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule